// File: doc/BRIEF.md
# Programmable Down-Counting Counter/Timer

This block is a 16-bit down-counter that serves a serial controller as either a free-running square-wave generator (timer mode) or a one-shot terminal-count detector (counter mode). It advances on a counter clock enable. That enable is taken either directly or after a divide-by-16 prescaler. A CPU programs a reload value through a byte-wide register port. Start and stop commands are issued as side effects of reads at two fixed addresses. The CPU can also read back the live count one byte at a time.

The block drives a ready flag and a waveform pin. In timer mode the pin toggles every preset ticks and the flag marks each completed period. In counter mode the pin drops and the flag rises when the count reaches zero. The count then wraps and keeps running until a stop command.

Top module: `cnt_tmr`

## Requirements
- R1: After reset wave_o is 1, ready_o is 0, the live count is 0x0000, and the count does not move on enable pulses until a start command.
- R2: Writes at address 0x6 set the upper preset byte and writes at 0x7 set the lower byte. Reads at 0x6/0x7 return the upper/lower byte of the live count and never the preset.
- R3: A read at address 0xE (start) loads the preset into the count, sets wave_o to 1, clears the prescaler and begins a new cycle at once, even while a cycle is running.
- R4: In timer mode (timer_mode_i=1) wave_o toggles every P counter ticks, so the square-wave period is 2P ticks.
- R5: In timer mode a preset written mid half-period does not change that half-period. The new value is used from the next reload onward.
- R6: In timer mode ready_o sets once per full period, on the tick where wave_o returns high.
- R7: In timer mode a read at address 0xF (stop) clears ready_o in the next cycle and does not halt the square wave.
- R8: In counter mode (timer_mode_i=0) the count decrements once per tick. wave_o stays 1 until the count reaches 0x0000; on that tick wave_o goes 0 and ready_o goes 1.
- R9: In counter mode the count wraps from 0x0000 to 0xFFFF and keeps decrementing; ready_o stays 1 until a stop.
- R10: In counter mode a stop halts the count, drives wave_o to 1 and clears ready_o; the halted count stays readable and unchanged.
- R11: In counter mode a preset written while running takes effect only at the next start. With no new write, a later start reuses the last preset.
- R12: With div16_i=1 one counter tick occurs per 16 ct_en_i pulses, counted from the last start. With div16_i=0 every ct_en_i pulse is a tick.
- R13: A preset below 0x0002 is loaded as 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ct_en_i | input | 1 | Counter clock enable pulse |
| div16_i | input | 1 | 1: divide enable pulses by 16 |
| timer_mode_i | input | 1 | 1: timer (square wave), 0: counter (one-shot) |
| cs_i | input | 1 | Register chip select |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational during a read) |
| ready_o | output | 1 | Ready / terminal-count flag |
| wave_o | output | 1 | Square wave or terminal-count output |

## Verification
A start or stop read and each counter tick change the count, wave_o and ready_o at the first rising edge where the strobe or tick is present. The bench therefore compares both outputs against its reference model at the falling edge after every rising edge. Read data is combinational, so count bytes are sampled 1 ns after the address is set, inside the same low phase and before the next edge. Preset writes reach the count only through a later reload. The model reproduces this by taking the pre-edge preset for any load.

// File: rtl/cnt_tmr_pkg.sv
package cnt_tmr_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;
  // byte k of the preset / live count sits at A_BYTE0 - k
  localparam logic [ADDR_W-1:0] A_BYTE0 = 4'h7;
  localparam logic [ADDR_W-1:0] A_START = 4'hE;
  localparam logic [ADDR_W-1:0] A_STOP  = 4'hF;

  typedef struct packed {
    logic start;
    logic stop;
  } cmd_t;
endpackage

// File: rtl/cnt_tmr_regs.sv
module cnt_tmr_regs
  import cnt_tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MIN_PRESET = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  preset_o,
  output cmd_t              cmd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NB = CNT_W / DATA_W;
  localparam logic [CNT_W-1:0] RST_PRE = CNT_W'(MIN_PRESET);

  logic [DATA_W-1:0] pre_q [NB];
  logic rd_acc, wr_acc;

  assign rd_acc = cs_i & rd_i;
  assign wr_acc = cs_i & wr_i;

  assign cmd_o.start = rd_acc & (addr_i == A_START);
  assign cmd_o.stop  = rd_acc & (addr_i == A_STOP);

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam logic [ADDR_W-1:0] BADDR = A_BYTE0 - ADDR_W'(k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pre_q[k] <= RST_PRE[k*DATA_W +: DATA_W];
      else if (wr_acc && addr_i == BADDR) pre_q[k] <= wdata_i;
    end

    assign preset_o[k*DATA_W +: DATA_W] = pre_q[k];
  end

  // reads at byte addresses expose the live count, never the preset
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (rd_acc && addr_i == (A_BYTE0 - ADDR_W'(k))) rdata_o = cnt_i[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cnt_tmr_prescale.sv
module cnt_tmr_prescale #(
  parameter int unsigned PRE_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div_i,
  input  logic clr_i,
  output logic tick_o
);
  if (PRE_DIV <= 1) begin : g_direct
    assign tick_o = en_i;
  end else begin : g_div
    localparam int unsigned PW = $clog2(PRE_DIV);
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
    logic [PW-1:0] pc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              pc_q <= '0;
      else if (clr_i)           pc_q <= '0;
      else if (en_i && div_i)   pc_q <= (pc_q == LAST) ? '0 : pc_q + PW'(1);
    end

    assign tick_o = en_i & (~div_i | (pc_q == LAST));
  end
endmodule

// File: rtl/cnt_tmr_core.sv
module cnt_tmr_core #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MIN_PRESET = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             timer_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             wave_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PRESET);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, eff_pre;
  logic run_q, wave_q, rdy_q;

  assign eff_pre = (preset_i < MIN_V) ? MIN_V : preset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= eff_pre;
      run_q  <= 1'b1;
      wave_q <= 1'b1;
    end else begin
      if (run_q && tick_i) begin
        if (timer_i) begin
          // reload samples the preset here: mid half-period writes apply next time
          if (cnt_q <= ONE) begin
            cnt_q  <= eff_pre;
            wave_q <= ~wave_q;
            if (!wave_q) rdy_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end else begin
          cnt_q <= cnt_q - ONE;  // wraps past zero
          if (cnt_q == ONE) begin
            rdy_q  <= 1'b1;
            wave_q <= 1'b0;
          end
        end
      end
      if (stop_i) begin
        rdy_q <= 1'b0;
        if (!timer_i) begin
          run_q  <= 1'b0;
          wave_q <= 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign run_o   = run_q;
  assign wave_o  = wave_q;
  assign ready_o = rdy_q;
endmodule

// File: rtl/cnt_tmr.sv
module cnt_tmr
  import cnt_tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PRE_DIV    = 16,
  parameter int unsigned MIN_PRESET = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ct_en_i,
  input  logic              div16_i,
  input  logic              timer_mode_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              wave_o
);
  cmd_t             cmd;
  logic [CNT_W-1:0] preset, cnt_q;
  logic             tick, run;

  cnt_tmr_regs #(.CNT_W(CNT_W), .MIN_PRESET(MIN_PRESET)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_q),
    .preset_o(preset),
    .cmd_o   (cmd),
    .rdata_o (rdata_o)
  );

  cnt_tmr_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ct_en_i),
    .div_i (div16_i),
    .clr_i (cmd.start),
    .tick_o(tick)
  );

  cnt_tmr_core #(.CNT_W(CNT_W), .MIN_PRESET(MIN_PRESET)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .timer_i (timer_mode_i),
    .tick_i  (tick),
    .start_i (cmd.start),
    .stop_i  (cmd.stop),
    .preset_i(preset),
    .cnt_o   (cnt_q),
    .run_o   (run),
    .wave_o  (wave_o),
    .ready_o (ready_o)
  );
endmodule

// File: rtl/cnt_tmr_chk.sv
module cnt_tmr_chk #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MIN_PRESET = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ct_en_i,
  input logic             timer_i,
  input logic             tick_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wave_i,
  input logic             ready_i
);
  a_r1_idle_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(cnt_i));

  a_r3_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_i && wave_i && cnt_i >= CNT_W'(MIN_PRESET)));

  a_r4_wave_moves_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wave_i) |-> $past(tick_i || start_i || stop_i));

  a_r6_ready_sets_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_i) |-> $past(tick_i && run_i));

  a_r7_stop_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !ready_i);

  a_r8_low_at_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wave_i) && $past(!timer_i)) |-> (cnt_i == '0 && ready_i));

  a_r9_ready_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !stop_i) |=> ready_i);

  a_r10_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !timer_i) |=> (!run_i && wave_i));

  a_r12_tick_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> ct_en_i);
endmodule

bind cnt_tmr cnt_tmr_chk #(.CNT_W(CNT_W), .MIN_PRESET(MIN_PRESET)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ct_en_i(ct_en_i),
  .timer_i(timer_mode_i),
  .tick_i (tick),
  .start_i(cmd.start),
  .stop_i (cmd.stop),
  .run_i  (run),
  .cnt_i  (cnt_q),
  .wave_i (wave_o),
  .ready_i(ready_o)
);

// File: tb/cnt_tmr_tb_top.sv
module cnt_tmr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ct_en = 1'b0, div16 = 1'b0, timer = 1'b1;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ready, wave;

  int checks = 0, fails = 0;
  string tag = "R1";
  int en_per = 0;
  int cyc = 0;

  // reference model state
  logic [15:0] m_cnt, m_pre;
  bit m_run, m_wave, m_rdy;
  int m_pc;

  always #5 clk = ~clk;

  cnt_tmr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ct_en_i(ct_en), .div16_i(div16),
    .timer_mode_i(timer), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ready_o(ready), .wave_o(wave)
  );

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  function automatic logic [15:0] eff(logic [15:0] p);
    return (p < 16'd2) ? 16'd2 : p;
  endfunction

  always @(negedge clk) begin
    cyc++;
    ct_en = (en_per > 0) && (cyc % en_per == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_wave = 1; m_rdy = 0; m_pre = 16'd2; m_pc = 0;
    end else begin
      bit st, sp, tk;
      st = cs && rd && addr == 4'hE;
      sp = cs && rd && addr == 4'hF;
      tk = ct_en && (!div16 || m_pc == 15);
      if (st) begin
        m_cnt = eff(m_pre); m_run = 1; m_wave = 1;
      end else begin
        if (m_run && tk) begin
          if (timer) begin
            if (m_cnt <= 1) begin
              m_cnt = eff(m_pre);
              if (!m_wave) m_rdy = 1;
              m_wave = !m_wave;
            end else m_cnt = m_cnt - 1;
          end else begin
            if (m_cnt == 1) begin m_rdy = 1; m_wave = 0; end
            m_cnt = m_cnt - 1;
          end
        end
        if (sp) begin
          m_rdy = 0;
          if (!timer) begin m_run = 0; m_wave = 1; end
        end
      end
      if (st) m_pc = 0;
      else if (ct_en && div16) m_pc = (m_pc + 1) % 16;
      if (cs && wr && addr == 4'h6) m_pre[15:8] = wdata;
      if (cs && wr && addr == 4'h7) m_pre[7:0] = wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " wave"}, wave, m_wave);
      check({tag, " ready"}, ready, m_rdy);
    end
  end

  task automatic cmd_rd(logic [3:0] a);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic wr_pre(logic [15:0] v);
    wr_reg(4'h6, v[15:8]);
    wr_reg(4'h7, v[7:0]);
  endtask

  task automatic read_cnt(string t, output logic [15:0] v);
    @(negedge clk); cs = 1; rd = 1; addr = 4'h6;
    #1 v[15:8] = rdata; check({t, " cnt_hi"}, rdata, m_cnt[15:8]);
    addr = 4'h7;
    #1 v[7:0] = rdata; check({t, " cnt_lo"}, rdata, m_cnt[7:0]);
    cs = 0; rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    int tg;
    bit prev;
    #23 rst_n = 1;
    @(negedge clk);
    check("R1 reset wave", wave, 1);
    check("R1 reset ready", ready, 0);
    en_per = 1;
    idle(40);
    read_cnt("R1", v);
    check("R1 idle count", v, 16'h0000);

    // clamp of tiny preset
    tag = "R13"; en_per = 0; timer = 1;
    wr_pre(16'h0001);
    cmd_rd(4'hE);
    read_cnt("R13", v);
    check("R13 clamp", v, 16'h0002);

    tag = "R3";
    wr_pre(16'h0005);
    cmd_rd(4'hE);
    read_cnt("R3", v);
    check("R3 load", v, 16'h0005);

    tag = "R4"; en_per = 1;
    idle(60);
    tag = "R6";
    idle(30);
    check("R6 ready set", ready, 1);

    tag = "R7";
    cmd_rd(4'hF);
    check("R7 ready cleared", ready, 0);
    tg = 0; prev = wave;
    repeat (30) begin
      @(negedge clk);
      if (wave != prev) tg++;
      prev = wave;
    end
    check("R7 still toggling", tg > 0, 1);

    tag = "R5";
    wr_pre(16'h0003);
    idle(40);
    tag = "R3";
    idle(2);
    cmd_rd(4'hE);
    idle(20);

    // counter mode
    tag = "R8"; en_per = 0;
    cmd_rd(4'hF);
    timer = 0;
    wr_pre(16'h0004);
    cmd_rd(4'hE);
    check("R8 high before terminal", wave, 1);
    en_per = 1;
    idle(6);
    check("R8 low at terminal", wave, 0);
    check("R8 ready at terminal", ready, 1);

    tag = "R9";
    idle(10);
    read_cnt("R9", v);
    check("R9 wrapped hi", v[15:8], 8'hFF);
    check("R9 ready held", ready, 1);

    tag = "R11";
    wr_pre(16'h0007);
    idle(5);

    tag = "R10";
    cmd_rd(4'hF);
    check("R10 wave high", wave, 1);
    check("R10 ready clear", ready, 0);
    read_cnt("R10", v);
    idle(10);
    read_cnt("R10", v2);
    check("R10 halted", v2, v);

    tag = "R11"; en_per = 0;
    cmd_rd(4'hE);
    read_cnt("R11", v);
    check("R11 new preset at start", v, 16'h0007);
    cmd_rd(4'hF);
    cmd_rd(4'hE);
    read_cnt("R11", v);
    check("R11 preset kept", v, 16'h0007);

    tag = "R2";
    cmd_rd(4'hF);
    wr_pre(16'h1234);
    read_cnt("R2", v);
    check("R2 reads count not preset", v, 16'h0007);

    tag = "R12"; timer = 1; div16 = 1;
    wr_pre(16'h0002);
    en_per = 1;
    cmd_rd(4'hE);
    idle(20);
    check("R12 still first half", wave, 1);
    idle(20);
    check("R12 second half", wave, 0);
    en_per = 3;
    idle(300);
    timer = 0;
    cmd_rd(4'hE);
    idle(200);
    cmd_rd(4'hF);
    idle(5);

    finish_run();
  end
endmodule